// File: doc/BRIEF.md
# Vectored interrupt and privilege controller

This block sits beside a simple in-order core and owns the processor's privilege state. It keeps one bit that says whether the core runs in supervisor or user mode. It also keeps a small table of handler entry addresses and a countdown timer. Requests come from three kinds of source: external device lines, the timer on expiry, and a software-interrupt (syscall) instruction. When a request is accepted, the block tells the core to redirect fetch to the handler address for that source. In the same step it saves the address of the instruction that would have issued next, saves the previous mode, forces supervisor mode and masks further interrupts.

The mode bit can only be lowered by an explicit instruction. The only way back into supervisor mode is to take an interrupt, so a timer armed before user code runs always returns control to the supervisor. A return instruction restores both the saved address and the saved mode. While the core is in user mode, any configuration write, privileged operation or return is refused and reported on a fault pulse.

The core presents the address of its next instruction on `cur_pc` every cycle. Whenever `redirect` is high, the core must discard that instruction and fetch from `redirect_pc`.

Top module: `irq_priv_ctrl`

## Requirements
- R1: After reset the block is in supervisor mode with interrupts masked (`irq_on`=0), and `redirect` and `priv_fault` are low.
- R2: A request that is accepted at a clock edge produces, for the next cycle only, `redirect`=1 and `redirect_pc` equal to the table entry for the source. Table index 0 is the timer, index 1 is the software interrupt and index 2+i is device line i. `cause` carries the index.
- R3: When several requests are pending, exactly one is taken per edge. The timer comes first, then the software interrupt, then device lines from lowest index upward. The others stay pending.
- R4: Taking a request stores `cur_pc` of that cycle in `epc`, saves the current mode, enters supervisor mode and clears `irq_on`.
- R5: A return (`ret_req`) in supervisor mode with nothing being taken redirects to `epc`, restores the saved mode and sets `irq_on`=1. A take in the same cycle has precedence over the return.
- R6: `drop_req` in supervisor mode switches to user mode at the next edge. In user mode it has no effect. Supervisor mode is entered only by taking a request.
- R7: In supervisor mode a request is accepted only while `irq_on`=1. In user mode any pending request is accepted.
- R8: A timer write of value V>0 (`cfg_sel`=1, low bits of `cfg_data`) raises the timer request at the V-th edge after the write edge. V=0 disarms the timer. The request stays pending until it is taken.
- R9: A `swi_req` pulse, in either mode, latches a software-interrupt request that stays pending until it is taken.
- R10: Configuration writes take effect only in supervisor mode: `cfg_sel`=0 writes table entry `cfg_idx`, 1 loads the timer, 2 sets `irq_on` from `cfg_data[0]`, 3 does nothing. In user mode `cfg_we`, `priv_op` or `ret_req` leaves all state unchanged and sets `priv_fault` for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | AW | Address of the instruction about to issue |
| dev_irq | input | NDEV | Level requests from devices |
| swi_req | input | 1 | Software-interrupt instruction executed |
| ret_req | input | 1 | Return-from-handler instruction |
| drop_req | input | 1 | Instruction that switches to user mode |
| priv_op | input | 1 | Core attempts a privileged instruction or memory access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 table, 1 timer, 2 interrupt enable |
| cfg_idx | input | IW | Table entry index |
| cfg_data | input | AW | Write data |
| redirect | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | AW | Handler or return address |
| cause | output | IW | Index of the source last taken |
| epc | output | AW | Saved return address |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| irq_on | output | 1 | Interrupt enable used in supervisor mode |
| priv_fault | output | 1 | Pulse after a refused privileged action |

## Verification
Directed sequences first put the timer, the syscall and two device lines in flight together, so that only the fixed order of R3 explains the observed sequence of causes. They then count edges after a timer load to pin the expiry cycle, and finally drop to user mode and try a table write that a later take must prove was discarded. Seeded random traffic then mixes short timer loads, syscall pulses, device levels, returns, mode drops and configuration writes in both modes. A bench model compares every output on every cycle, which separates mistakes in precedence (take against return, return against enable write) from mistakes in the mode-save path.

// File: rtl/irq_priv_ctrl.sv
module irq_priv_ctrl #(
  parameter int NDEV = 4,
  parameter int AW   = 32,
  parameter int TW   = 16,
  localparam int NVEC = NDEV + 2,
  localparam int IW   = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cur_pc,
  input  logic [NDEV-1:0] dev_irq,
  input  logic            swi_req,
  input  logic            ret_req,
  input  logic            drop_req,
  input  logic            priv_op,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_data,
  output logic            redirect,
  output logic [AW-1:0]   redirect_pc,
  output logic [IW-1:0]   cause,
  output logic [AW-1:0]   epc,
  output logic            sup_mode,
  output logic            irq_on,
  output logic            priv_fault
);

  logic [AW-1:0] vec [NVEC];
  logic [TW-1:0] tcnt;
  logic          tarm, tpend, spend, pmode;
  logic [NVEC-1:0] req;
  logic [IW-1:0] pick;
  logic          found, accept, sup_wr;

  assign req    = {dev_irq, spend, tpend};
  assign accept = (|req) && (irq_on || !sup_mode);
  assign sup_wr = cfg_we && sup_mode;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NVEC; i++)
      if (req[i] && !found) begin
        pick  = IW'(i);
        found = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVEC; i++) vec[i] <= '0;
      tcnt <= '0; tarm <= 1'b0; tpend <= 1'b0; spend <= 1'b0;
      pmode <= 1'b1; sup_mode <= 1'b1; irq_on <= 1'b0;
      redirect <= 1'b0; redirect_pc <= '0; cause <= '0; epc <= '0;
      priv_fault <= 1'b0;
    end else begin
      redirect   <= 1'b0;
      priv_fault <= !sup_mode && (cfg_we || priv_op || ret_req);

      if (sup_wr && cfg_sel == 2'd0 && int'(cfg_idx) < NVEC) vec[cfg_idx] <= cfg_data;
      if (sup_wr && cfg_sel == 2'd2) irq_on <= cfg_data[0];

      if (accept) begin
        redirect    <= 1'b1;
        redirect_pc <= vec[pick];
        cause       <= pick;
        epc         <= cur_pc;
        pmode       <= sup_mode;
        sup_mode    <= 1'b1;
        irq_on      <= 1'b0;
        if (pick == IW'(0)) tpend <= 1'b0;
        if (pick == IW'(1)) spend <= 1'b0;
      end else if (ret_req && sup_mode) begin
        redirect    <= 1'b1;
        redirect_pc <= epc;
        sup_mode    <= pmode;
        irq_on      <= 1'b1;
      end else if (drop_req && sup_mode) begin
        sup_mode <= 1'b0;
      end

      if (sup_wr && cfg_sel == 2'd1) begin
        tcnt <= cfg_data[TW-1:0];
        tarm <= |cfg_data[TW-1:0];
      end else if (tarm) begin
        tcnt <= tcnt - 1'b1;
        if (tcnt == TW'(1)) begin
          tarm  <= 1'b0;
          tpend <= 1'b1;
        end
      end

      if (swi_req) spend <= 1'b1;
    end
  end

endmodule

module irq_priv_ctrl_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NDEV-1:0] dev_irq,
  input logic            ret_req,
  input logic            priv_op,
  input logic            cfg_we,
  input logic            redirect,
  input logic            sup_mode,
  input logic            irq_on,
  input logic            priv_fault
);

  // R6
  sup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_mode) |-> (redirect && !irq_on));

  // R4
  user_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && $past(!sup_mode)) |-> sup_mode);

  // R7
  user_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sup_mode && (|dev_irq)) |-> redirect);

  // R10
  user_cfg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && !sup_mode) |-> priv_fault);

  // R10
  user_op_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((priv_op || ret_req) && !sup_mode) |-> priv_fault);

endmodule

bind irq_priv_ctrl irq_priv_ctrl_chk #(.NDEV(NDEV)) chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ret_req(ret_req),
  .priv_op(priv_op), .cfg_we(cfg_we), .redirect(redirect),
  .sup_mode(sup_mode), .irq_on(irq_on), .priv_fault(priv_fault)
);

// File: tb/irq_priv_ctrl_test.sv
module irq_priv_ctrl_test;
  localparam int NDEV = 4, AW = 32, TW = 16;
  localparam int NVEC = NDEV + 2, IW = $clog2(NVEC);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cur_pc = '0, cfg_data = '0;
  logic [NDEV-1:0] dev_irq = '0;
  logic swi_req = 0, ret_req = 0, drop_req = 0, priv_op = 0, cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic redirect, sup_mode, irq_on, priv_fault;
  logic [AW-1:0] redirect_pc, epc;
  logic [IW-1:0] cause;

  irq_priv_ctrl #(.NDEV(NDEV), .AW(AW), .TW(TW)) uut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [AW-1:0] m_vec [NVEC];
  logic [TW-1:0] m_cnt;
  logic m_arm, m_tp, m_sp, m_pm, m_sup, m_ie, m_red, m_flt;
  logic [AW-1:0] m_rpc, m_epc;
  logic [IW-1:0] m_cause;

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NVEC; i++) m_vec[i] = '0;
    m_cnt = '0; m_arm = 0; m_tp = 0; m_sp = 0; m_pm = 1; m_sup = 1; m_ie = 0;
    m_red = 0; m_flt = 0; m_rpc = '0; m_epc = '0; m_cause = '0;
  endtask

  task automatic idle();
    dev_irq = '0; swi_req = 0; ret_req = 0; drop_req = 0; priv_op = 0; cfg_we = 0;
  endtask

  task automatic tick();
    logic [NVEC-1:0] r;
    logic acc, fnd;
    int pk;
    logic [AW-1:0] nvec [NVEC];
    logic [TW-1:0] ncnt;
    logic narm, ntp, nsp, npm, nsup, nie, nred, nflt;
    logic [AW-1:0] nrpc, nepc;
    logic [IW-1:0] ncause;
    for (int i = 0; i < NVEC; i++) nvec[i] = m_vec[i];
    ncnt = m_cnt; narm = m_arm; ntp = m_tp; nsp = m_sp; npm = m_pm; nsup = m_sup;
    nie = m_ie; nrpc = m_rpc; nepc = m_epc; ncause = m_cause;
    r = {dev_irq, m_sp, m_tp};
    acc = (|r) && (m_ie || !m_sup);
    pk = 0; fnd = 0;
    for (int i = 0; i < NVEC; i++) if (r[i] && !fnd) begin pk = i; fnd = 1; end
    nred = 0;
    nflt = !m_sup && (cfg_we || priv_op || ret_req);
    if (m_sup && cfg_we && cfg_sel == 0 && int'(cfg_idx) < NVEC) nvec[cfg_idx] = cfg_data;
    if (m_sup && cfg_we && cfg_sel == 2) nie = cfg_data[0];
    if (acc) begin
      nred = 1; nrpc = m_vec[pk]; ncause = IW'(pk); nepc = cur_pc;
      npm = m_sup; nsup = 1; nie = 0;
      if (pk == 0) ntp = 0;
      if (pk == 1) nsp = 0;
    end else if (ret_req && m_sup) begin
      nred = 1; nrpc = m_epc; nsup = m_pm; nie = 1;
    end else if (drop_req && m_sup) nsup = 0;
    if (m_sup && cfg_we && cfg_sel == 1) begin
      ncnt = cfg_data[TW-1:0]; narm = |cfg_data[TW-1:0];
    end else if (m_arm) begin
      ncnt = m_cnt - 1'b1;
      if (m_cnt == TW'(1)) begin narm = 0; ntp = 1; end
    end
    if (swi_req) nsp = 1;
    @(posedge clk); #2;
    for (int i = 0; i < NVEC; i++) m_vec[i] = nvec[i];
    m_cnt = ncnt; m_arm = narm; m_tp = ntp; m_sp = nsp; m_pm = npm; m_sup = nsup;
    m_ie = nie; m_red = nred; m_flt = nflt; m_rpc = nrpc; m_epc = nepc; m_cause = ncause;
    check("R2 redirect", AW'(redirect), AW'(m_red));
    if (m_red) begin
      check("R2 redirect_pc", redirect_pc, m_rpc);
      check("R3 cause", AW'(cause), AW'(m_cause));
    end
    check("R4 epc", epc, m_epc);
    check("R6 sup_mode", AW'(sup_mode), AW'(m_sup));
    check("R7 irq_on", AW'(irq_on), AW'(m_ie));
    check("R10 priv_fault", AW'(priv_fault), AW'(m_flt));
  endtask

  task automatic cfg(logic [1:0] sel, logic [IW-1:0] idx, logic [AW-1:0] d);
    idle(); cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_data = d; tick(); idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog: got 0 expected 1 (run completion)");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7311));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1
    check("R1 sup_mode", AW'(sup_mode), 1);
    check("R1 irq_on", AW'(irq_on), 0);
    check("R1 redirect", AW'(redirect), 0);
    check("R1 priv_fault", AW'(priv_fault), 0);

    for (int i = 0; i < NVEC; i++) cfg(2'd0, IW'(i), AW'(32'h100 * (i + 1)));
    cfg(2'd2, '0, 1);

    // R2 R4 device take
    idle(); dev_irq = 4'b0100; cur_pc = 32'h40; tick(); idle();
    check("R2 dev vector", redirect_pc, 32'h500);
    check("R2 dev cause", AW'(cause), 4);
    check("R4 epc", epc, 32'h40);
    check("R4 masked", AW'(irq_on), 0);
    // R5
    ret_req = 1; tick(); idle();
    check("R5 return pc", redirect_pc, 32'h40);
    check("R5 enable", AW'(irq_on), 1);

    // R3 R9 priority with three sources pending
    cfg(2'd2, '0, 0);
    swi_req = 1; tick(); idle();
    cfg(2'd1, '0, 1);
    tick();
    dev_irq = 4'b0011; cfg_we = 1; cfg_sel = 2'd2; cfg_data = 1; tick();
    cfg_we = 0; tick();
    check("R3 timer first", AW'(cause), 0);
    check("R3 timer vector", redirect_pc, 32'h100);
    ret_req = 1; tick(); ret_req = 0; tick();
    check("R9 swi second", AW'(cause), 1);
    ret_req = 1; tick(); ret_req = 0; tick();
    check("R3 dev0 third", AW'(cause), 2);
    idle(); ret_req = 1; tick(); idle();

    // R8 timer expiry cycle
    cfg(2'd1, '0, 5);
    for (int k = 1; k <= 5; k++) begin
      tick();
      check("R8 not yet", AW'(redirect), 0);
    end
    tick();
    check("R8 expiry", AW'(redirect), 1);
    check("R8 cause", AW'(cause), 0);
    ret_req = 1; tick(); idle();

    // R6 R7 R10 user mode
    cfg(2'd2, '0, 0);
    drop_req = 1; tick(); idle();
    check("R6 user", AW'(sup_mode), 0);
    cfg(2'd0, IW'(4), 32'hDEAD);
    check("R10 fault", AW'(priv_fault), 1);
    drop_req = 1; tick(); idle();
    check("R6 drop in user", AW'(sup_mode), 0);
    ret_req = 1; tick(); idle();
    check("R10 ret refused", AW'(redirect), 0);
    check("R10 ret fault", AW'(priv_fault), 1);
    dev_irq = 4'b0100; cur_pc = 32'h88; tick();
    check("R7 user accepts", AW'(redirect), 1);
    check("R10 vector kept", redirect_pc, 32'h500);
    check("R4 enter sup", AW'(sup_mode), 1);
    tick();
    check("R7 masked in sup", AW'(redirect), 0);
    idle(); ret_req = 1; tick(); idle();
    check("R5 back to user", AW'(sup_mode), 0);
    swi_req = 1; tick(); idle(); tick();
    check("R9 syscall", AW'(cause), 1);
    check("R9 sup", AW'(sup_mode), 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      cur_pc = $urandom;
      for (int d = 0; d < NDEV; d++) dev_irq[d] = ($urandom % 16) == 0;
      swi_req  = ($urandom % 20) == 0;
      ret_req  = ($urandom % 6) == 0;
      drop_req = ($urandom % 8) == 0;
      priv_op  = ($urandom % 10) == 0;
      cfg_we   = ($urandom % 5) == 0;
      cfg_sel  = 2'($urandom % 4);
      cfg_idx  = IW'($urandom % 8);
      cfg_data = (cfg_sel == 2'd1) ? AW'($urandom % 30) : AW'($urandom);
      tick();
    end
    idle();
    done = 1;
    finish_run();
  end
endmodule